// File: doc/BRIEF.md
# Hoisted Load Conflict Guard

When a compiler moves a load above one or more earlier stores, this block tracks whether that move was safe. Each speculative load places its address and access size in a table slot selected by the load's destination register number. Every store issued after that is compared against the armed slots. A store whose byte range overlaps a slot's range marks that slot as clobbered.

A check operation sits at the load's original place in the program. It names the same register, the address to reload from, whether dependent operations were hoisted along with the load, and the address of a repair routine. One cycle after the check, the block returns one of three verdicts. The first is a pass. The second is a request to repeat the load at the check point. The third is a redirect to the repair routine. A check always frees its slot.

Each table slot is a three-state machine:
- EMPTY moves to ARMED when a load names the slot.
- ARMED moves to CLOBBERED when an overlapping store arrives.
- ARMED or CLOBBERED moves to EMPTY when a check names the slot.
- Any state moves to ARMED when a new load names the slot. This load is ordered after a check and after a store in the same cycle.

The response stage is a registered output with two conditions, IDLE and VALID. It reports a verdict only in the cycle after a check.

Top module: `spec_ld_guard`

## Requirements
- R1: After reset, every slot is EMPTY and `rsp_valid` is 0. A check issued after reset fails, and it fails again even if a load was armed just before the reset.
- R2: A load arms the slot indexed by `ld_reg` with the load's address and size. A check of that register with no conflicting store in between gives `rsp_kind` PASS (code 0) with `rsp_target` 0.
- R3: The access size code s (0..3) covers 2^s bytes, starting at the address rounded down to a multiple of 2^s. A store conflicts with a slot when both fall in the same 8-byte granule (address bits above bit 2 are equal) and their byte masks within the granule overlap.
- R4: A store in another granule, or in the same granule with disjoint bytes, leaves the slot ARMED.
- R5: A failed check with `ck_has_deps`=0 returns RELOAD (code 1), with `rsp_target`=`ck_addr` and `rsp_reg`=`ck_reg`.
- R6: A failed check with `ck_has_deps`=1 returns FIXUP (code 2), with `rsp_target`=`ck_fixup`.
- R7: A check of a slot that is not ARMED counts as a failure.
- R8: A check returns its slot to EMPTY, so a second check of the same register fails.
- R9: A new load to a register overwrites its slot and clears any earlier clobber.
- R10: A store in the same cycle as a check is applied first, so an overlapping store makes that check fail.
- R11: A load and a check of the same register in the same cycle: the check judges the old entry, and the load then arms a fresh entry.
- R12: A store in the same cycle as a load to an overlapping address is treated as older than the load and does not clobber it.
- R13: `rsp_valid` is 1 exactly in the cycle after a check and 0 otherwise. A check or store leaves the slots of other registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Speculative load issued |
| ld_reg | input | REG_W | Destination register of the load (selects the slot) |
| ld_addr | input | ADDR_W | Byte address of the load |
| ld_size | input | 2 | Load size code (2^s bytes) |
| st_valid | input | 1 | Store issued |
| st_addr | input | ADDR_W | Byte address of the store |
| st_size | input | 2 | Store size code (2^s bytes) |
| ck_valid | input | 1 | Check operation issued |
| ck_reg | input | REG_W | Register whose slot is checked |
| ck_addr | input | ADDR_W | Address to reload from on failure |
| ck_has_deps | input | 1 | Dependent operations were hoisted with the load |
| ck_fixup | input | ADDR_W | Repair routine address |
| rsp_valid | output | 1 | Verdict valid (cycle after a check) |
| rsp_kind | output | 2 | 0 PASS, 1 RELOAD, 2 FIXUP |
| rsp_reg | output | REG_W | Register of the check |
| rsp_target | output | ADDR_W | Reload or repair address; 0 on PASS |

## Verification
The assertions check on every cycle that a verdict follows each check by exactly one cycle, and that the verdict echoes the check's register. They also check that the verdict kind is legal and matches the check's dependency flag, and that the target is 0, `ck_addr` or `ck_fixup` as the kind requires. The scenarios in the bench are needed to show which verdict is correct. That covers byte-overlap decisions at granule edges, the clear after a check, overwriting by a new load, and the ordering of a store, load and check issued in the same cycle.

// File: rtl/slg_pkg.sv
package slg_pkg;

    typedef enum logic [1:0] {
        RSP_PASS   = 2'd0,
        RSP_RELOAD = 2'd1,
        RSP_FIXUP  = 2'd2
    } rsp_kind_e;

    typedef enum logic [1:0] {
        SLOT_EMPTY     = 2'd0,
        SLOT_ARMED     = 2'd1,
        SLOT_CLOBBERED = 2'd2
    } slot_state_e;

    // Byte lanes touched inside one 8-byte granule by an access of 2^sz bytes.
    function automatic logic [7:0] lane_mask(input logic [2:0] off, input logic [1:0] sz);
        logic [3:0] nbytes;
        logic [8:0] ones;
        logic [2:0] base;
        nbytes = 4'd1 << sz;
        ones   = (9'd1 << nbytes) - 9'd1;
        base   = off & ~3'(nbytes - 4'd1);
        return ones[7:0] << base;
    endfunction

endpackage

// File: rtl/slg_slot.sv
module slg_slot
    import slg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [ADDR_W-1:0] arm_addr,
    input  logic [1:0]        arm_size,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [1:0]        st_size,
    input  logic              consume,
    output logic              clean
);
    localparam int GRAN_LSB = 3;

    slot_state_e       state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        size_q;
    logic              st_hit;

    assign st_hit = st_valid
                 && (st_addr[ADDR_W-1:GRAN_LSB] == addr_q[ADDR_W-1:GRAN_LSB])
                 && |(lane_mask(st_addr[2:0], st_size) & lane_mask(addr_q[2:0], size_q));

    // Verdict seen by a check this cycle: the store is already applied.
    assign clean = (state_q == SLOT_ARMED) && !st_hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY:     state_d = SLOT_EMPTY;
            SLOT_ARMED:     if (st_hit) state_d = SLOT_CLOBBERED;
            SLOT_CLOBBERED: state_d = SLOT_CLOBBERED;
            default:        state_d = SLOT_EMPTY;
        endcase
        if (consume) state_d = SLOT_EMPTY;
        if (arm)     state_d = SLOT_ARMED;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
            addr_q  <= '0;
            size_q  <= '0;
        end else begin
            state_q <= state_d;
            if (arm) begin
                addr_q <= arm_addr;
                size_q <= arm_size;
            end
        end
    end

endmodule

// File: rtl/slg_resp.sv
module slg_resp
    import slg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int REG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ck_valid,
    input  logic [REG_W-1:0]  ck_reg,
    input  logic [ADDR_W-1:0] ck_addr,
    input  logic              ck_has_deps,
    input  logic [ADDR_W-1:0] ck_fixup,
    input  logic              entry_ok,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [REG_W-1:0]  rsp_reg,
    output logic [ADDR_W-1:0] rsp_target
);
    rsp_kind_e         kind_d;
    logic [ADDR_W-1:0] tgt_d;

    always_comb begin
        kind_d = RSP_PASS;
        tgt_d  = '0;
        if (!entry_ok) begin
            if (ck_has_deps) begin
                kind_d = RSP_FIXUP;
                tgt_d  = ck_fixup;
            end else begin
                kind_d = RSP_RELOAD;
                tgt_d  = ck_addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_kind   <= RSP_PASS;
            rsp_reg    <= '0;
            rsp_target <= '0;
        end else begin
            rsp_valid <= ck_valid;
            if (ck_valid) begin
                rsp_kind   <= kind_d;
                rsp_reg    <= ck_reg;
                rsp_target <= tgt_d;
            end
        end
    end

endmodule

// File: rtl/spec_ld_guard.sv
module spec_ld_guard
    import slg_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int REG_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [REG_W-1:0]  ld_reg,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [1:0]        ld_size,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [1:0]        st_size,
    input  logic              ck_valid,
    input  logic [REG_W-1:0]  ck_reg,
    input  logic [ADDR_W-1:0] ck_addr,
    input  logic              ck_has_deps,
    input  logic [ADDR_W-1:0] ck_fixup,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [REG_W-1:0]  rsp_reg,
    output logic [ADDR_W-1:0] rsp_target
);
    localparam int SLOTS = 1 << REG_W;

    logic [SLOTS-1:0] slot_clean;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        slg_slot #(.ADDR_W(ADDR_W)) slot_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .arm      (ld_valid && (ld_reg == REG_W'(g))),
            .arm_addr (ld_addr),
            .arm_size (ld_size),
            .st_valid (st_valid),
            .st_addr  (st_addr),
            .st_size  (st_size),
            .consume  (ck_valid && (ck_reg == REG_W'(g))),
            .clean    (slot_clean[g])
        );
    end

    slg_resp #(.ADDR_W(ADDR_W), .REG_W(REG_W)) resp_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ck_valid    (ck_valid),
        .ck_reg      (ck_reg),
        .ck_addr     (ck_addr),
        .ck_has_deps (ck_has_deps),
        .ck_fixup    (ck_fixup),
        .entry_ok    (slot_clean[ck_reg]),
        .rsp_valid   (rsp_valid),
        .rsp_kind    (rsp_kind),
        .rsp_reg     (rsp_reg),
        .rsp_target  (rsp_target)
    );

endmodule

// File: rtl/slg_guard_chk.sv
module slg_guard_chk #(
    parameter int ADDR_W = 32,
    parameter int REG_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ck_valid,
    input logic [REG_W-1:0]  ck_reg,
    input logic [ADDR_W-1:0] ck_addr,
    input logic              ck_has_deps,
    input logic [ADDR_W-1:0] ck_fixup,
    input logic              rsp_valid,
    input logic [1:0]        rsp_kind,
    input logic [REG_W-1:0]  rsp_reg,
    input logic [ADDR_W-1:0] rsp_target
);
    p_rsp_after_check_r13: assert property (@(posedge clk) disable iff (!rst_n)
        ck_valid |=> rsp_valid);

    p_no_rsp_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !ck_valid |=> !rsp_valid);

    p_reg_echo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ck_valid |=> rsp_reg == $past(ck_reg));

    p_legal_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_kind != 2'd3);

    p_pass_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 2'd0) |-> rsp_target == '0);

    p_reload_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_valid && !ck_has_deps) |=> (rsp_kind != 2'd2)
            && (rsp_kind == 2'd0 || rsp_target == $past(ck_addr)));

    p_fixup_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_valid && ck_has_deps) |=> (rsp_kind != 2'd1)
            && (rsp_kind == 2'd0 || rsp_target == $past(ck_fixup)));

endmodule

bind spec_ld_guard slg_guard_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ck_valid    (ck_valid),
    .ck_reg      (ck_reg),
    .ck_addr     (ck_addr),
    .ck_has_deps (ck_has_deps),
    .ck_fixup    (ck_fixup),
    .rsp_valid   (rsp_valid),
    .rsp_kind    (rsp_kind),
    .rsp_reg     (rsp_reg),
    .rsp_target  (rsp_target)
);

// File: tb/spec_ld_guard_tb.sv
module spec_ld_guard_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int RW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_valid = 1'b0;
    logic [RW-1:0] ld_reg = '0;
    logic [AW-1:0] ld_addr = '0;
    logic [1:0]    ld_size = '0;
    logic          st_valid = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic [1:0]    st_size = '0;
    logic          ck_valid = 1'b0;
    logic [RW-1:0] ck_reg = '0;
    logic [AW-1:0] ck_addr = '0;
    logic          ck_has_deps = 1'b0;
    logic [AW-1:0] ck_fixup = '0;
    logic          rsp_valid;
    logic [1:0]    rsp_kind;
    logic [RW-1:0] rsp_reg;
    logic [AW-1:0] rsp_target;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spec_ld_guard #(.ADDR_W(AW), .REG_W(RW)) dut_i (.*);

    typedef struct packed {
        logic [3:0]  rq;
        logic        lv; logic [2:0] lr; logic [31:0] la; logic [1:0] ls;
        logic        sv; logic [31:0] sa; logic [1:0] ss;
        logic        cv; logic [2:0] cr; logic [31:0] ca; logic cd; logic [31:0] cf;
        logic [1:0]  ek; logic [31:0] et;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VECS [NV] = '{
        // R2: arm r1 with an 8-byte load, then check it
        '{4'd2, 1'b1,3'd1,32'h100,2'd3, 1'b0,32'h0,2'd0,   1'b0,3'd0,32'h0,1'b0,32'h0,      2'd0,32'h0},
        '{4'd2, 1'b0,3'd0,32'h0,2'd0,   1'b0,32'h0,2'd0,   1'b1,3'd1,32'h100,1'b0,32'h0,    2'd0,32'h0},
        // R8: second check of r1 fails and reloads
        '{4'd8, 1'b0,3'd0,32'h0,2'd0,   1'b0,32'h0,2'd0,   1'b1,3'd1,32'h100,1'b0,32'h0,    2'd1,32'h100},
        // R4: disjoint lanes in the same granule, then another granule
        '{4'd4, 1'b1,3'd2,32'h204,2'd2, 1'b0,32'h0,2'd0,   1'b0,3'd0,32'h0,1'b0,32'h0,      2'd0,32'h0},
        '{4'd4, 1'b0,3'd0,32'h0,2'd0,   1'b1,32'h200,2'd2, 1'b0,3'd0,32'h0,1'b0,32'h0,      2'd0,32'h0},
        '{4'd4, 1'b0,3'd0,32'h0,2'd0,   1'b1,32'h300,2'd3, 1'b0,3'd0,32'h0,1'b0,32'h0,      2'd0,32'h0},
        '{4'd4, 1'b0,3'd0,32'h0,2'd0,   1'b0,32'h0,2'd0,   1'b1,3'd2,32'h204,1'b1,32'h8000, 2'd0,32'h0},
        // R3 + R5: 8-byte store covers a 2-byte load, reload requested
        '{4'd3, 1'b1,3'd3,32'h40A,2'd1, 1'b0,32'h0,2'd0,   1'b0,3'd0,32'h0,1'b0,32'h0,      2'd0,32'h0},
        '{4'd3, 1'b0,3'd0,32'h0,2'd0,   1'b1,32'h408,2'd3, 1'b0,3'd0,32'h0,1'b0,32'h0,      2'd0,32'h0},
        '{4'd5, 1'b0,3'd0,32'h0,2'd0,   1'b0,32'h0,2'd0,   1'b1,3'd3,32'h40A,1'b0,32'h0,    2'd1,32'h40A},
        // R6: byte load, neighbour byte store misses, exact byte store hits
        '{4'd6, 1'b1,3'd4,32'h500,2'd0, 1'b0,32'h0,2'd0,   1'b0,3'd0,32'h0,1'b0,32'h0,      2'd0,32'h0},
        '{4'd6, 1'b0,3'd0,32'h0,2'd0,   1'b1,32'h501,2'd0, 1'b0,3'd0,32'h0,1'b0,32'h0,      2'd0,32'h0},
        '{4'd6, 1'b0,3'd0,32'h0,2'd0,   1'b1,32'h500,2'd0, 1'b0,3'd0,32'h0,1'b0,32'h0,      2'd0,32'h0},
        '{4'd6, 1'b0,3'd0,32'h0,2'd0,   1'b0,32'h0,2'd0,   1'b1,3'd4,32'h500,1'b1,32'h9000, 2'd2,32'h9000},
        // R7: check of a register never loaded
        '{4'd7, 1'b0,3'd0,32'h0,2'd0,   1'b0,32'h0,2'd0,   1'b1,3'd5,32'h550,1'b1,32'hA000, 2'd2,32'hA000},
        // R9: clobbered slot re-armed by a new load
        '{4'd9, 1'b1,3'd6,32'h600,2'd2, 1'b0,32'h0,2'd0,   1'b0,3'd0,32'h0,1'b0,32'h0,      2'd0,32'h0},
        '{4'd9, 1'b0,3'd0,32'h0,2'd0,   1'b1,32'h600,2'd2, 1'b0,3'd0,32'h0,1'b0,32'h0,      2'd0,32'h0},
        '{4'd9, 1'b1,3'd6,32'h600,2'd2, 1'b0,32'h0,2'd0,   1'b0,3'd0,32'h0,1'b0,32'h0,      2'd0,32'h0},
        '{4'd9, 1'b0,3'd0,32'h0,2'd0,   1'b0,32'h0,2'd0,   1'b1,3'd6,32'h600,1'b0,32'h0,    2'd0,32'h0},
        // R10: store and check in the same cycle
        '{4'd10,1'b1,3'd7,32'h700,2'd3, 1'b0,32'h0,2'd0,   1'b0,3'd0,32'h0,1'b0,32'h0,      2'd0,32'h0},
        '{4'd10,1'b0,3'd0,32'h0,2'd0,   1'b1,32'h704,2'd0, 1'b1,3'd7,32'h700,1'b0,32'h0,    2'd1,32'h700},
        // R11: load and check of r0 in the same cycle
        '{4'd11,1'b1,3'd0,32'h800,2'd3, 1'b0,32'h0,2'd0,   1'b0,3'd0,32'h0,1'b0,32'h0,      2'd0,32'h0},
        '{4'd11,1'b1,3'd0,32'h900,2'd3, 1'b0,32'h0,2'd0,   1'b1,3'd0,32'h800,1'b0,32'h0,    2'd0,32'h0},
        '{4'd11,1'b0,3'd0,32'h0,2'd0,   1'b1,32'h800,2'd3, 1'b0,3'd0,32'h0,1'b0,32'h0,      2'd0,32'h0},
        '{4'd11,1'b0,3'd0,32'h0,2'd0,   1'b0,32'h0,2'd0,   1'b1,3'd0,32'h900,1'b0,32'h0,    2'd0,32'h0},
        // R12: load and overlapping store in the same cycle
        '{4'd12,1'b1,3'd1,32'hA00,2'd2, 1'b1,32'hA00,2'd2, 1'b0,3'd0,32'h0,1'b0,32'h0,      2'd0,32'h0},
        '{4'd12,1'b0,3'd0,32'h0,2'd0,   1'b0,32'h0,2'd0,   1'b1,3'd1,32'hA00,1'b0,32'h0,    2'd0,32'h0},
        // R13: checking one slot leaves another armed slot alone
        '{4'd13,1'b1,3'd2,32'hB00,2'd3, 1'b0,32'h0,2'd0,   1'b0,3'd0,32'h0,1'b0,32'h0,      2'd0,32'h0},
        '{4'd13,1'b1,3'd3,32'hC00,2'd3, 1'b0,32'h0,2'd0,   1'b0,3'd0,32'h0,1'b0,32'h0,      2'd0,32'h0},
        '{4'd13,1'b0,3'd0,32'h0,2'd0,   1'b0,32'h0,2'd0,   1'b1,3'd2,32'hB00,1'b0,32'h0,    2'd0,32'h0},
        '{4'd13,1'b0,3'd0,32'h0,2'd0,   1'b1,32'hB00,2'd3, 1'b1,3'd3,32'hC00,1'b0,32'h0,    2'd0,32'h0}
    };

    task automatic drive(input vec_t v);
        ld_valid = v.lv; ld_reg = v.lr; ld_addr = v.la; ld_size = v.ls;
        st_valid = v.sv; st_addr = v.sa; st_size = v.ss;
        ck_valid = v.cv; ck_reg = v.cr; ck_addr = v.ca; ck_has_deps = v.cd; ck_fixup = v.cf;
    endtask

    task automatic expect_rsp(input int rq, input logic v, input logic [1:0] k,
                              input logic [2:0] r, input logic [31:0] t);
        checks++;
        if (rsp_valid !== v || (v && (rsp_kind !== k || rsp_reg !== r || rsp_target !== t))) begin
            failures++;
            $display("FAIL R%0d: got v=%0b kind=%0d reg=%0d tgt=%h, expected v=%0b kind=%0d reg=%0d tgt=%h",
                     rq, rsp_valid, rsp_kind, rsp_reg, rsp_target, v, k, r, t);
        end
    endtask

    initial begin
        vec_t idle;
        idle = '0;
        // R1: outputs quiet during and right after reset
        repeat (3) @(posedge clk);
        #1 expect_rsp(1, 1'b0, 2'd0, 3'd0, 32'h0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1 expect_rsp(1, 1'b0, 2'd0, 3'd0, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk) drive(VECS[i]);
            @(posedge clk); #1;
            expect_rsp(int'(VECS[i].rq), VECS[i].cv, VECS[i].ek, VECS[i].cr, VECS[i].et);
        end
        @(negedge clk) drive(idle);
        @(posedge clk); #1 expect_rsp(13, 1'b0, 2'd0, 3'd0, 32'h0);

        // R1: an armed slot is dropped by reset
        @(negedge clk) begin ld_valid = 1'b1; ld_reg = 3'd5; ld_addr = 32'hD00; ld_size = 2'd3; end
        @(negedge clk) begin ld_valid = 1'b0; rst_n = 1'b0; end
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk) begin ck_valid = 1'b1; ck_reg = 3'd5; ck_addr = 32'hD00; ck_has_deps = 1'b0; end
        @(posedge clk); #1 expect_rsp(1, 1'b1, 2'd1, 3'd5, 32'hD00);
        @(negedge clk) ck_valid = 1'b0;

        // R3: size-4 load at unaligned offset 6 rounds down to lanes 4..7; store to lane 4 hits
        @(negedge clk) begin ld_valid = 1'b1; ld_reg = 3'd2; ld_addr = 32'hE06; ld_size = 2'd2; end
        @(negedge clk) begin ld_valid = 1'b0; st_valid = 1'b1; st_addr = 32'hE04; st_size = 2'd0; end
        @(negedge clk) begin st_valid = 1'b0; ck_valid = 1'b1; ck_reg = 3'd2; ck_addr = 32'hE06;
                             ck_has_deps = 1'b1; ck_fixup = 32'hF00; end
        @(posedge clk); #1 expect_rsp(3, 1'b1, 2'd2, 3'd2, 32'hF00);
        @(negedge clk) ck_valid = 1'b0;

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule